// File: doc/BRIEF.md
# Condition Flag Register

This block holds the four arithmetic condition flags of a 32-bit integer datapath: negative, zero, carry and overflow. Every cycle it looks at what the execute stage produced (result word, adder carry-out, operand sign bits, shifter carry-out) together with an operation class, a per-instruction set-flags request and a condition-passed bit. From these it decides which flags to rewrite and which to keep. Flags that the operation class does not touch keep their old value.

A separate write port loads all four flags at once for status-register move instructions, and it wins over any ALU update in the same cycle. The adder, the shifter and the condition evaluator sit outside the block. For subtraction the adder is expected to form A + ~B + 1, so its carry-out is already the inverted borrow.

Top module: `cond_flag_reg`

## Requirements
- R1: While rst_ni is low, flags_o is 4'b0000. The bit order is [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: On any ALU update, N takes result_i[31] and Z is 1 exactly when result_i is all zeros.
- R3: For the add classes (0 add, 2 compare-negative) C takes adder_cy_i, the unsigned carry out of bit 31. For the subtract classes (1 subtract, 3 compare) C also takes adder_cy_i, which is 1 when there is no borrow and 0 when there is a borrow.
- R4: For the add classes, V is 1 when both operand signs are equal and the result sign differs from them, and 0 otherwise.
- R5: For the subtract classes, V is computed as in R4 but with the inverted sign of operand B.
- R6: For the logical classes (4 logical, 5 test), C takes shift_cy_i when shift_cy_vld_i is 1 and keeps its old value otherwise. V always keeps its old value.
- R7: Classes 0, 1 and 4 update the flags only when set_flags_i is 1. Classes 2, 3 and 5 update the flags whatever the value of set_flags_i.
- R8: When cond_pass_i is 0, no ALU update takes place and all four flags stay unchanged.
- R9: When flag_wr_i is 1, flags_o takes flag_wr_data_i on the next clock edge. This holds whatever the ALU inputs, set_flags_i and cond_pass_i are.
- R10: Classes 6 and 7 leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 32 | ALU result word |
| adder_cy_i | input | 1 | Adder carry-out (for subtraction, carry-out of A + ~B + 1) |
| op_a_sign_i | input | 1 | Sign bit of operand A |
| op_b_sign_i | input | 1 | Sign bit of operand B before any inversion |
| shift_cy_i | input | 1 | Last bit shifted out by the shifter |
| shift_cy_vld_i | input | 1 | Shifter carry is meaningful (the shift amount is non-zero) |
| op_class_i | input | 3 | Operation class: 0 add, 1 sub, 2 cmp-neg, 3 cmp, 4 logical, 5 test, 6/7 none |
| set_flags_i | input | 1 | Set-flags request from the instruction |
| cond_pass_i | input | 1 | The instruction's condition passed |
| flag_wr_i | input | 1 | Direct flag load strobe |
| flag_wr_data_i | input | 4 | Direct flag value {N,Z,C,V} |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
On every cycle the assertions check the hold rules: a failed condition, an ordinary operation without set-flags, and classes 6 and 7 all leave the flags stable. They also check that a direct load always wins, that compare and test operations always write N and Z from the result, and that logical classes never disturb V. The arithmetic values of C and V need particular sign and carry combinations, and so does carry preservation when the shifter carry is not valid. These are shown only by the bench's vector table. The table chains expected values from one operation to the next, and the directed tests add a mid-run reset and a direct load that collides with an ALU update.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_CMN  = 3'd2,
    OPC_CMP  = 3'd3,
    OPC_LOG  = 3'd4,
    OPC_TST  = 3'd5,
    OPC_NOP6 = 3'd6,
    OPC_NOP7 = 3'd7
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned NUM_FLAGS = 4;

endpackage

// File: rtl/nzcv_calc.sv
module nzcv_calc
  import cond_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              adder_cy_i,
  input  logic              op_a_sign_i,
  input  logic              op_b_sign_i,
  input  logic              shift_cy_i,
  input  logic              shift_cy_vld_i,
  input  op_class_e         op_class_i,
  output nzcv_t             val_o,
  output nzcv_t             touch_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic is_add, is_sub, is_log;
  logic b_eff;

  always_comb begin
    is_add = (op_class_i == OPC_ADD) || (op_class_i == OPC_CMN);
    is_sub = (op_class_i == OPC_SUB) || (op_class_i == OPC_CMP);
    is_log = (op_class_i == OPC_LOG) || (op_class_i == OPC_TST);
    // subtract feeds the adder with ~B
    b_eff  = is_sub ? ~op_b_sign_i : op_b_sign_i;

    val_o.n = result_i[MSB];
    val_o.z = (result_i == '0);
    val_o.c = is_log ? shift_cy_i : adder_cy_i;
    val_o.v = (op_a_sign_i == b_eff) && (result_i[MSB] != op_a_sign_i);

    touch_o.n = is_add || is_sub || is_log;
    touch_o.z = is_add || is_sub || is_log;
    touch_o.c = is_add || is_sub || (is_log && shift_cy_vld_i);
    touch_o.v = is_add || is_sub;
  end

endmodule

// File: rtl/nzcv_gate.sv
module nzcv_gate
  import cond_flag_pkg::*;
(
  input  op_class_e op_class_i,
  input  logic      set_flags_i,
  input  logic      cond_pass_i,
  output logic      upd_en_o
);
  logic always_wr, opt_wr;

  always_comb begin
    always_wr = (op_class_i == OPC_CMN) || (op_class_i == OPC_CMP) ||
                (op_class_i == OPC_TST);
    opt_wr    = (op_class_i == OPC_ADD) || (op_class_i == OPC_SUB) ||
                (op_class_i == OPC_LOG);
    upd_en_o  = cond_pass_i && (always_wr || (opt_wr && set_flags_i));
  end

endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import cond_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              adder_cy_i,
  input  logic              op_a_sign_i,
  input  logic              op_b_sign_i,
  input  logic              shift_cy_i,
  input  logic              shift_cy_vld_i,
  input  logic [2:0]        op_class_i,
  input  logic              set_flags_i,
  input  logic              cond_pass_i,
  input  logic              flag_wr_i,
  input  logic [NUM_FLAGS-1:0] flag_wr_data_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_class_e opc;
  nzcv_t     calc_val, calc_touch;
  logic      upd_en;
  logic [NUM_FLAGS-1:0] flags_q, flags_d;

  assign opc = op_class_e'(op_class_i);

  nzcv_calc #(.DATA_W(DATA_W)) u_calc (
    .result_i       (result_i),
    .adder_cy_i     (adder_cy_i),
    .op_a_sign_i    (op_a_sign_i),
    .op_b_sign_i    (op_b_sign_i),
    .shift_cy_i     (shift_cy_i),
    .shift_cy_vld_i (shift_cy_vld_i),
    .op_class_i     (opc),
    .val_o          (calc_val),
    .touch_o        (calc_touch)
  );

  nzcv_gate u_gate (
    .op_class_i  (opc),
    .set_flags_i (set_flags_i),
    .cond_pass_i (cond_pass_i),
    .upd_en_o    (upd_en)
  );

  // per-flag merge; direct load overrides
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_merge
    always_comb begin
      if (flag_wr_i)
        flags_d[i] = flag_wr_data_i[i];
      else if (upd_en && calc_touch[i])
        flags_d[i] = calc_val[i];
      else
        flags_d[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R9
  a_r9_direct_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i |=> flags_o == $past(flag_wr_data_i));

  // R8
  a_r8_cond_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_pass_i && !flag_wr_i) |=> $stable(flags_o));

  // R7
  a_r7_no_request_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr_i && !set_flags_i &&
     (op_class_i == 3'd0 || op_class_i == 3'd1 || op_class_i == 3'd4))
    |=> $stable(flags_o));

  // R7, R2: compare/test always write N and Z
  a_r7_compare_writes_nz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr_i && cond_pass_i &&
     (op_class_i == 3'd2 || op_class_i == 3'd3 || op_class_i == 3'd5))
    |=> (flags_o[3] == $past(result_i[MSB])) &&
        (flags_o[2] == ($past(result_i) == '0)));

  // R6
  a_r6_logic_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr_i && (op_class_i == 3'd4 || op_class_i == 3'd5))
    |=> flags_o[0] == $past(flags_o[0]));

  // R10
  a_r10_idle_class_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr_i && op_class_i[2:1] == 2'b11) |=> $stable(flags_o));

endmodule

// File: tb/tb_cond_flag_reg.sv
module tb_cond_flag_reg;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] result_i = '0;
  logic        adder_cy_i = 1'b0, op_a_sign_i = 1'b0, op_b_sign_i = 1'b0;
  logic        shift_cy_i = 1'b0, shift_cy_vld_i = 1'b0;
  logic [2:0]  op_class_i = 3'd6;
  logic        set_flags_i = 1'b0, cond_pass_i = 1'b0;
  logic        flag_wr_i = 1'b0;
  logic [3:0]  flag_wr_data_i = '0;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  cond_flag_reg dut (
    .clk_i, .rst_ni, .result_i, .adder_cy_i, .op_a_sign_i, .op_b_sign_i,
    .shift_cy_i, .shift_cy_vld_i, .op_class_i, .set_flags_i, .cond_pass_i,
    .flag_wr_i, .flag_wr_data_i, .flags_o
  );

  typedef struct packed {
    logic [31:0] res;
    logic        cy, sa, sb, shc, shv;
    logic [2:0]  cls;
    logic        sf, cond;
    logic [3:0]  exp;   // {N,Z,C,V}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0, 1'b1,1'b1, 4'b0110, 4'd2},  // R2 R3 add zero carry
    '{32'h8000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 1'b1,1'b1, 4'b1001, 4'd4},  // R4 positive overflow
    '{32'h7FFF_FFFF, 1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0, 1'b1,1'b1, 4'b0011, 4'd4},  // R4 negative overflow
    '{32'h0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd1, 1'b1,1'b1, 4'b0110, 4'd3},  // R3 sub no borrow
    '{32'hFFFF_FFFF, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1, 1'b1,1'b1, 4'b1000, 4'd3},  // R3 sub borrow
    '{32'h8000_0001, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd1, 1'b1,1'b1, 4'b1001, 4'd5},  // R5 sub overflow
    '{32'h0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b1, 4'b1001, 4'd7},  // R7 add without request
    '{32'h0000_0000, 1'b1,1'b1,1'b1,1'b0,1'b0, 3'd3, 1'b0,1'b1, 4'b0110, 4'd7},  // R7 compare always
    '{32'h8000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b1, 4'b1001, 4'd7},  // R7 cmp-neg always
    '{32'h0000_0000, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd4, 1'b1,1'b1, 4'b0111, 4'd6},  // R6 shifter carry
    '{32'h8000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4, 1'b1,1'b1, 4'b1011, 4'd6},  // R6 no shift keeps C
    '{32'h0000_0000, 1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5, 1'b0,1'b1, 4'b0101, 4'd6},  // R6 test always
    '{32'h8000_0000, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd4, 1'b0,1'b1, 4'b0101, 4'd7},  // R7 logical no request
    '{32'h8000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd3, 1'b1,1'b0, 4'b0101, 4'd8},  // R8 condition failed
    '{32'h8000_0000, 1'b1,1'b0,1'b0,1'b1,1'b1, 3'd6, 1'b1,1'b1, 4'b0101, 4'd10}, // R10 class 6
    '{32'h0000_0000, 1'b1,1'b1,1'b0,1'b1,1'b1, 3'd7, 1'b1,1'b1, 4'b0101, 4'd10}, // R10 class 7
    '{32'h1234_5678, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 1'b1,1'b1, 4'b0000, 4'd2}   // R2 plain result
  };

  task automatic check(input logic [3:0] exp, input int req, input string what);
    checks++;
    if (flags_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: flags_o=%b expected=%b", req, what, flags_o, exp);
    end
  endtask

  task automatic drive_vec(input vec_t v);
    result_i = v.res; adder_cy_i = v.cy; op_a_sign_i = v.sa; op_b_sign_i = v.sb;
    shift_cy_i = v.shc; shift_cy_vld_i = v.shv; op_class_i = v.cls;
    set_flags_i = v.sf; cond_pass_i = v.cond;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with an active ALU update presented
    result_i = 32'h8000_0000; op_class_i = 3'd3; cond_pass_i = 1'b1; adder_cy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(4'b0000, 1, "in reset");
    op_class_i = 3'd6; cond_pass_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(4'b0000, 1, "after reset release");

    for (int i = 0; i < NV; i++) begin
      drive_vec(VEC[i]);
      @(negedge clk_i);
      check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R9 direct load collides with an executing compare
    drive_vec('{32'h0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd3, 1'b1,1'b1, 4'b0000, 4'd9});
    flag_wr_i = 1'b1; flag_wr_data_i = 4'b1010;
    @(negedge clk_i);
    check(4'b1010, 9, "load beats compare");

    // R9 direct load with condition failed
    cond_pass_i = 1'b0; flag_wr_data_i = 4'b0101;
    @(negedge clk_i);
    check(4'b0101, 9, "load with cond fail");
    flag_wr_i = 1'b0;
    op_class_i = 3'd6;
    @(negedge clk_i);
    check(4'b0101, 9, "held after load");

    // R1 mid-run asynchronous reset
    flag_wr_i = 1'b1; flag_wr_data_i = 4'b1111;
    @(negedge clk_i);
    check(4'b1111, 9, "load all ones");
    flag_wr_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check(4'b0000, 1, "async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(4'b0000, 1, "after second release");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule